// File: doc/BRIEF.md
# Pin Takeover Sequence Detector

This block sits beside the quadrature output drivers of an encoder device. While the device is in normal service it drives quadrature waveforms onto a pair of differential pins. An external tool that wants to configure the device overpowers those drivers and forces a timed, four-step level pattern onto the pins. The block watches the pins through a synchronizer and a short glitch filter. Once it has seen the whole pattern with the right timing, it releases the pin drivers and hands the pins to a serial configuration link.

The first step is timed against fixed limits, given as parameters in clock cycles. Its measured length then becomes the yardstick for the three steps that follow: each must match it to within plus or minus one tenth, with the tenth rounded down. A wrong level, a step that is too short or too long, or a step out of order sends the detector back to idle. Once the link has been handed over, it stays handed over until reset.

The block carries no data stream. Both outputs are plain control levels, so there is no valid/ready handshake and no back-pressure.

Top module: `pin_takeover_detector`

## Requirements
- R1: After reset `drv_en_o` is 1 and `link_on_o` is 0.
- R2: The steps, written as {pin_p_i, pin_n_i}, are 11, then 01, then 00, then 10, in that order only. A different next pattern returns the detector to idle and does not enable the link.
- R3: The first step (11) is accepted only if its filtered length L lies in [T1_MIN, T1_MAX] clock cycles.
- R4: Each of steps two to four must last between L - floor(L/10) and L + floor(L/10) cycles inclusive. A shorter step returns the detector to idle.
- R5: If step one has lasted more than T1_MAX cycles, or step two or three has lasted more than the upper bound, the detector returns to idle at once, without waiting for the pins to change.
- R6: Step four ends when the pins leave 10 with its length inside the window. It also ends, and is accepted, when the pins stay at 10 past the upper bound.
- R7: `link_on_o` rises on the same clock edge on which `drv_en_o` falls. After that, `link_on_o` stays 1 and `drv_en_o` stays 0 until reset, whatever the pins do.
- R8: A pin pulse shorter than FILT_LEN cycles is filtered out and does not change the measured length of any step.
- R9: From idle, a new attempt starts only on a fresh change into 11. Short quadrature steps never enable the link, and a pin pair that stays at 11 after an abort does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_p_i | input | 1 | Logic level seen on the positive pin |
| pin_n_i | input | 1 | Logic level seen on the negative pin |
| drv_en_o | output | 1 | 1 while the device may drive quadrature onto the pins |
| link_on_o | output | 1 | 1 once the serial configuration link owns the pins |

## Verification
The bench builds the block with T1_MIN=40 and T1_MAX=200 cycles, FILT_LEN=3 and two synchronizer stages. This shrinks a millisecond-scale sequence to a few hundred cycles, so a single run can cover every window edge. With a 100-cycle first step the window becomes exactly 90..110, and both edges and the values just outside them are driven. The first-step limits 40 and 200, and the values 39 and 201, are driven as well. Glitches of two and four cycles probe each side of the filter length.

// File: rtl/takeover_pkg.sv
package takeover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP1,
    ST_STEP2,
    ST_STEP3,
    ST_STEP4,
    ST_LINK
  } tko_state_e;

  // {positive pin, negative pin} level expected in each step
  localparam logic [1:0] PAT_S1 = 2'b11;
  localparam logic [1:0] PAT_S2 = 2'b01;
  localparam logic [1:0] PAT_S3 = 2'b00;
  localparam logic [1:0] PAT_S4 = 2'b10;
endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FW-1:0] RUN_LAST = FW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FW-1:0]          run_q;
  logic                   level_q;
  logic                   sampled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign sampled = sync_q[SYNC_STAGES-1];

  // level follows the synchronized pin only after FILT_LEN equal samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (sampled == level_q) begin
      run_q <= '0;
    end else if (run_q == RUN_LAST) begin
      run_q   <= '0;
      level_q <= sampled;
    end else begin
      run_q <= run_q + FW'(1);
    end
  end

  assign level_o = level_q;

  // R8: a filtered edge always moves toward the synchronized level
  a_r8_edge_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (level_q == $past(sampled)));
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             capture_i,
  output logic [CNT_W-1:0] len_o,
  output logic [CNT_W-1:0] base_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);
  localparam logic [CNT_W-1:0] TEN = CNT_W'(10);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] tenth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              len_q <= '0;
    else if (restart_i)      len_q <= CNT_W'(1);
    else if (len_q != TOP)   len_q <= len_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (capture_i) base_q <= len_q;
  end

  assign tenth  = base_q / TEN;
  assign len_o  = len_q;
  assign base_o = base_q;
  assign lo_o   = base_q - tenth;
  assign hi_o   = base_q + tenth;

  // R4: length restarts at one on every new pattern
  a_r4_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (len_q == CNT_W'(1)));
endmodule

// File: rtl/takeover_fsm.sv
module takeover_fsm
  import takeover_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int T1_MIN = 40,
  parameter int T1_MAX = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pat_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             restart_o,
  output logic             capture_o,
  output logic             drv_en_o,
  output logic             link_on_o
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(T1_MIN);
  localparam logic [CNT_W-1:0] MAX_L = CNT_W'(T1_MAX);

  tko_state_e state_q, state_d;
  logic [1:0] pat_q;
  logic       chg;
  logic       in_win;
  logic       link_q, drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= 2'b00;
    else        pat_q <= pat_i;
  end

  assign chg    = (pat_i != pat_q);
  assign in_win = (len_i >= lo_i) && (len_i <= hi_i);

  always_comb begin
    state_d   = state_q;
    restart_o = chg;
    capture_o = 1'b0;
    case (state_q)
      ST_IDLE:
        if (chg && pat_i == PAT_S1) state_d = ST_STEP1;
      ST_STEP1:
        if (chg) begin
          if (pat_i == PAT_S2 && len_i >= MIN_L && len_i <= MAX_L) begin
            state_d   = ST_STEP2;
            capture_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (len_i >= MAX_L) begin
          state_d = ST_IDLE;
        end
      ST_STEP2:
        if (chg) state_d = (pat_i == PAT_S3 && in_win) ? ST_STEP3 : ST_IDLE;
        else if (len_i >= hi_i) state_d = ST_IDLE;
      ST_STEP3:
        if (chg) state_d = (pat_i == PAT_S4 && in_win) ? ST_STEP4 : ST_IDLE;
        else if (len_i >= hi_i) state_d = ST_IDLE;
      ST_STEP4:
        if (chg) state_d = in_win ? ST_LINK : ST_IDLE;
        else if (len_i >= hi_i) state_d = ST_LINK;
      ST_LINK:
        state_d = ST_LINK;
      default:
        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      link_q  <= 1'b0;
      drv_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      link_q  <= (state_d == ST_LINK);
      drv_q   <= (state_d != ST_LINK);
    end
  end

  assign drv_en_o  = drv_q;
  assign link_on_o = link_q;

  // R7: handover is permanent until reset
  a_r7_link_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    link_q |=> link_q);
  // R7: drivers released on the very edge the link comes up
  a_r7_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_q) |-> $fell(drv_q));
  // R3: a captured reference always lies inside the first-step limits
  a_r3_base_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP2) |-> (base_i >= MIN_L && base_i <= MAX_L));
  // R5: steps two and three never run past their upper bound
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP2 || state_q == ST_STEP3) |-> (len_i <= hi_i));
  // R5: step one never runs past its fixed limit
  a_r5_step1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP1) |-> (len_i <= MAX_L));
endmodule

// File: rtl/pin_takeover_detector.sv
module pin_takeover_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int T1_MIN      = 25000,
  parameter int T1_MAX      = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_p_i,
  input  logic pin_n_i,
  output logic drv_en_o,
  output logic link_on_o
);
  localparam int CNT_W = $clog2(T1_MAX + T1_MAX / 10 + 2);

  logic [1:0]       raw;
  logic [1:0]       pat;
  logic [CNT_W-1:0] len, base, lo, hi;
  logic             restart, capture;

  assign raw = {pin_p_i, pin_n_i};

  for (genvar i = 0; i < 2; i++) begin : g_pin
    pin_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_dg (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (raw[i]),
      .level_o(pat[i])
    );
  end

  step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .capture_i(capture),
    .len_o    (len),
    .base_o   (base),
    .lo_o     (lo),
    .hi_o     (hi)
  );

  takeover_fsm #(
    .CNT_W (CNT_W),
    .T1_MIN(T1_MIN),
    .T1_MAX(T1_MAX)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pat_i    (pat),
    .len_i    (len),
    .base_i   (base),
    .lo_i     (lo),
    .hi_i     (hi),
    .restart_o(restart),
    .capture_o(capture),
    .drv_en_o (drv_en_o),
    .link_on_o(link_on_o)
  );
endmodule

// File: tb/tb_pin_takeover_detector.sv
module tb_pin_takeover_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_p = 1'b0;
  logic pin_n = 1'b0;
  logic drv_en, link_on;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit    link;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #5 clk = ~clk;

  pin_takeover_detector #(
    .SYNC_STAGES(2),
    .FILT_LEN   (3),
    .T1_MIN     (40),
    .T1_MAX     (200)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_p_i  (pin_p),
    .pin_n_i  (pin_n),
    .drv_en_o (drv_en),
    .link_on_o(link_on)
  );

  // monitor: pops one expectation per event and compares both outputs
  initial begin
    forever begin
      @(chk_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (link_on !== e.link || drv_en !== !e.link) begin
          n_bad++;
          $display("FAIL %s: link_on=%b drv_en=%b expected link_on=%b drv_en=%b",
                   e.tag, link_on, drv_en, e.link, !e.link);
        end
      end
    end
  end

  task automatic expect_out(input bit link, input string tag);
    exp_t e;
    e.link = link;
    e.tag  = tag;
    exp_q.push_back(e);
    ->chk_ev;
    @(negedge clk);
  endtask

  task automatic hold(input logic [1:0] p, input int n);
    {pin_p, pin_n} = p;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {pin_p, pin_n} = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_seq(input int a, input int b, input int c, input int d);
    hold(2'b11, a);
    hold(2'b01, b);
    hold(2'b00, c);
    hold(2'b10, d);
    hold(2'b00, 20);
  endtask

  task automatic one_case(input int a, input int b, input int c, input int d,
                          input bit link, input string tag);
    do_reset();
    run_seq(a, b, c, d);
    expect_out(link, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    expect_out(1'b0, "R1 reset state");
    do_reset();
    expect_out(1'b0, "R1 after reset release");

    one_case(100, 100, 100, 100, 1'b1, "R2 nominal sequence");
    one_case(100, 90, 110, 100, 1'b1, "R4 window edges 90/110");
    one_case(100, 89, 100, 100, 1'b0, "R4 step two one short");
    one_case(100, 100, 100, 89, 1'b0, "R4 step four one short");
    one_case(100, 111, 100, 100, 1'b0, "R5 step two one long");
    one_case(39, 39, 39, 39, 1'b0, "R3 first step below limit");
    one_case(40, 36, 44, 40, 1'b1, "R3 first step at lower limit");
    one_case(200, 220, 180, 200, 1'b1, "R3 first step at upper limit");
    one_case(201, 201, 201, 201, 1'b0, "R5 first step over limit");

    // R2: wrong order 11 -> 00
    do_reset();
    hold(2'b11, 100); hold(2'b00, 100); hold(2'b10, 100); hold(2'b01, 100);
    hold(2'b00, 20);
    expect_out(1'b0, "R2 out of order");

    // R6: step four held past upper bound is accepted while pins still at 10
    do_reset();
    hold(2'b11, 100); hold(2'b01, 100); hold(2'b00, 100); hold(2'b10, 140);
    expect_out(1'b1, "R6 timeout accept during step four");

    // R7: later pin activity does not undo the handover
    hold(2'b11, 100); hold(2'b01, 30); hold(2'b00, 5); hold(2'b10, 300);
    expect_out(1'b1, "R7 sticky after pin activity");

    // R8: a two-cycle glitch inside step two is filtered out
    do_reset();
    hold(2'b11, 100); hold(2'b01, 50); hold(2'b11, 2); hold(2'b01, 48);
    hold(2'b00, 100); hold(2'b10, 100); hold(2'b00, 20);
    expect_out(1'b1, "R8 short glitch ignored");

    // R8: a four-cycle pulse is real and breaks the sequence
    do_reset();
    hold(2'b11, 100); hold(2'b01, 50); hold(2'b11, 4); hold(2'b01, 46);
    hold(2'b00, 100); hold(2'b10, 100); hold(2'b00, 20);
    expect_out(1'b0, "R8 long pulse seen");

    // R9: stuck at 11 after abort does not restart
    do_reset();
    hold(2'b11, 250); hold(2'b01, 100); hold(2'b00, 100); hold(2'b10, 100);
    hold(2'b00, 20);
    expect_out(1'b0, "R9 no restart without fresh entry");

    // R9: quadrature traffic, then a valid sequence without reset
    do_reset();
    for (int k = 0; k < 20; k++) begin
      hold(2'b00, 10); hold(2'b10, 10); hold(2'b11, 10); hold(2'b01, 10);
    end
    hold(2'b00, 20);
    expect_out(1'b0, "R9 quadrature ignored");
    run_seq(100, 100, 100, 100);
    expect_out(1'b1, "R9 recovery after quadrature");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule